// File: doc/BRIEF.md
# Parallel NOR Flash Unlock-Sequence Command Engine

This block takes a single request from a host and turns it into the bus cycles a parallel NOR flash needs, for either a word program or a sector erase. Each command starts with a fixed two-write unlock prefix at fixed word offsets. The erase command repeats that prefix before its final write. After the last command write, the block polls the device. It reads the target address twice in a row and compares the toggle bit (bit 6) of the two reads. The operation is finished when the two reads agree.

If the fault bit (bit 5) shows up while bit 6 is still toggling, the block takes exactly one more pair of reads before it declares a device error. A clock-cycle timeout, whose limit is an input, guards the poll. When the poll ends with a timeout or a device error, the block writes the reset command to the target address. Every operation ends with a one-cycle done pulse that carries a result code.

Command offsets are word offsets. The bus address is the word address multiplied by the port width in bytes. The host sees the block as busy from the cycle after a request is accepted until the done pulse.

Top module: `nor_unlock_seq`

## Requirements
- R1: While reset is held and afterwards until a request arrives, `fl_we_n` and `fl_oe_n` are high, `busy` is low and `done` is low.
- R2: A program request (`req_erase`=0) makes exactly four writes, in this order: 0xAA at word 0x555, 0x55 at word 0x2AA, 0xA0 at word 0x555, then `req_data` at `req_addr`.
- R3: An erase request (`req_erase`=1) makes exactly six writes, in this order: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at `req_addr`.
- R4: Each bus address is the word address times DW/8 bytes. With DW=16, word 0x555 appears as 0xAAA and word 0x2AA appears as 0x554.
- R5: Each write holds `fl_we_n` low for exactly one cycle, followed by at least one cycle high. `fl_we_n` and `fl_oe_n` are never low together.
- R6: Polling works in rounds of three cycles: read, read, compare, with both reads at `req_addr`. If bit 6 of the two reads is equal, the operation ends with code 0 (ok) and no further bus activity.
- R7: Suppose a round shows bit 6 differing and bit 5 of the second read set. Then exactly one more round follows. If that round still shows bit 6 differing, the result is code 2 (device error) and 0xF0 is written at `req_addr`. If it shows bit 6 equal, the result is code 0.
- R8: The timeout counter is cleared during command writes and counts every polling cycle. Round n compares after 3n-1 polling cycles. If bit 6 still differs, no retry is pending, and 3n-1 >= `tmo_limit`, the result is code 1 (timeout) and 0xF0 is written at `req_addr`.
- R9: `done` is high for exactly one cycle per accepted request. `done_code` is valid with it and is always 0, 1 or 2. `busy` is low in the following cycle.
- R10: A `req_valid` seen while `busy` is high is ignored: it adds no bus write and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_erase | input | 1 | 1 = sector erase, 0 = word program |
| req_addr | input | AW | Target word address (sector base for erase) |
| req_data | input | DW | Data word to program |
| tmo_limit | input | TW | Poll timeout in clock cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 0 ok, 1 timeout, 2 device error |
| fl_addr | output | AW+log2(DW/8) | Flash byte address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, sampled at the clock edge ending a read cycle |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |

## Verification
The hardest case to reach from the ports is the single retry round. The bit 5 fault must arrive while bit 6 is still toggling, and the retry round must then either settle or keep toggling. The same applies to how the retry interacts with the timeout window. The bench's flash model answers each read from a per-test script, with a chosen count of toggling reads and a chosen fault flag. This steers the poll into the retry path with either outcome, into timeouts of zero and nonzero limit, and into multi-round success. An independent round-by-round model of the rules predicts the expected read count.

// File: rtl/nor_seq_pkg.sv
// Shared command codes, offsets and result encodings for the NOR flash
// unlock-sequence engine. Assumes the command byte sits in the low lane.
package nor_seq_pkg;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_ERS_ARM  = 8'h80;
    localparam logic [7:0] CMD_ERS_SECT = 8'h30;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

    localparam logic [11:0] OFS_KEY_A = 12'h555;
    localparam logic [11:0] OFS_KEY_B = 12'h2AA;

    localparam int BIT_TOGGLE = 6;
    localparam int BIT_FAULT  = 5;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_TMO    = 2'd1,
        RES_DEVERR = 2'd2
    } result_e;

    typedef enum logic [2:0] {
        VERD_AGAIN,
        VERD_RETRY,
        VERD_OK,
        VERD_TMO,
        VERD_ERR
    } verdict_e;

endpackage

// File: rtl/nor_step_rom.sv
// Command-step table: maps operation type and step index to the word
// address and data of one bus write. Assumes AW >= 12 so the fixed
// offsets fit. Purely combinational.
module nor_step_rom
    import nor_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          is_erase,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] w_addr,
    output logic [DW-1:0] w_data,
    output logic          last
);
    localparam logic [AW-1:0] KEY_A = AW'(OFS_KEY_A);
    localparam logic [AW-1:0] KEY_B = AW'(OFS_KEY_B);

    // Select the address/data pair for the current step.
    always_comb begin
        w_addr = KEY_A;
        w_data = DW'(CMD_UNLOCK_A);
        last   = 1'b0;
        if (!is_erase) begin
            case (step)
                3'd0: begin w_addr = KEY_A; w_data = DW'(CMD_UNLOCK_A); end
                3'd1: begin w_addr = KEY_B; w_data = DW'(CMD_UNLOCK_B); end
                3'd2: begin w_addr = KEY_A; w_data = DW'(CMD_PROGRAM);  end
                default: begin w_addr = tgt_addr; w_data = tgt_data; last = 1'b1; end
            endcase
        end else begin
            case (step)
                3'd0, 3'd3: begin w_addr = KEY_A; w_data = DW'(CMD_UNLOCK_A); end
                3'd1, 3'd4: begin w_addr = KEY_B; w_data = DW'(CMD_UNLOCK_B); end
                3'd2: begin w_addr = KEY_A; w_data = DW'(CMD_ERS_ARM); end
                default: begin w_addr = tgt_addr; w_data = DW'(CMD_ERS_SECT); last = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/nor_wait_timer.sv
// Saturating poll timer: cleared while commands are written, counts
// each polling cycle, flags expiry once the count reaches the limit.
module nor_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Count polling cycles, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && cnt_q != {TW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);

    // Once expired, stays expired until cleared unless the limit moves.
    assert_expiry_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr && run) |=> (expired || limit != $past(limit)));
endmodule

// File: rtl/nor_toggle_eval.sv
// Captures the two reads of a polling round and classifies the round
// from the toggle bit, the fault bit, the retry flag and timer expiry.
module nor_toggle_eval
    import nor_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_first,
    input  logic          cap_second,
    input  logic [DW-1:0] rdata,
    input  logic          retry_armed,
    input  logic          expired,
    output verdict_e      verdict
);
    logic [1:0] first_q;
    logic [1:0] second_q;
    logic       toggled;

    // Keep the toggle and fault bits of each read in the round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            if (cap_first)  first_q  <= {rdata[BIT_TOGGLE], rdata[BIT_FAULT]};
            if (cap_second) second_q <= {rdata[BIT_TOGGLE], rdata[BIT_FAULT]};
        end
    end

    assign toggled = first_q[1] ^ second_q[1];

    // Priority: settled, pending retry, timeout, new fault, keep polling.
    always_comb begin
        if (!toggled)         verdict = VERD_OK;
        else if (retry_armed) verdict = VERD_ERR;
        else if (expired)     verdict = VERD_TMO;
        else if (second_q[0]) verdict = VERD_RETRY;
        else                  verdict = VERD_AGAIN;
    end

    // The two captures of a round never happen in the same cycle.
    assert_one_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_first && cap_second));
endmodule

// File: rtl/nor_unlock_seq.sv
// Top of the NOR flash command engine. Accepts one program or erase
// request while idle, writes the unlock-prefixed command sequence, polls
// the toggle bit, handles the single fault retry and the timeout, writes
// the reset command on failure and pulses done with a result code.
// Assumes the flash returns read data by the clock edge ending a read cycle.
module nor_unlock_seq
    import nor_seq_pkg::*;
#(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int TW  = 16,
    localparam int SH  = $clog2(DW / 8),
    localparam int BAW = AW + SH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_erase,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_data,
    input  logic [TW-1:0]  tmo_limit,
    output logic           busy,
    output logic           done,
    output logic [1:0]     done_code,
    output logic [BAW-1:0] fl_addr,
    output logic [DW-1:0]  fl_wdata,
    input  logic [DW-1:0]  fl_rdata,
    output logic           fl_we_n,
    output logic           fl_oe_n
);
    typedef enum logic [3:0] {
        ST_IDLE, ST_WLO, ST_WHI, ST_RD1, ST_RD2, ST_CHK, ST_RLO, ST_RHI, ST_DONE
    } state_e;

    state_e        state_q;
    logic [2:0]    step_q;
    logic          erase_q;
    logic          retry_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    result_e       code_q;

    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data;
    logic          rom_last;
    logic          expired;
    verdict_e      verdict;
    logic [AW-1:0] word_addr;
    logic          in_write;
    logic          in_poll;

    nor_step_rom #(.AW(AW), .DW(DW)) u_rom (
        .is_erase (erase_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .w_addr   (rom_addr),
        .w_data   (rom_data),
        .last     (rom_last)
    );

    assign in_write = (state_q == ST_WLO) || (state_q == ST_WHI);
    assign in_poll  = (state_q == ST_RD1) || (state_q == ST_RD2) || (state_q == ST_CHK);

    nor_wait_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_poll),
        .run     (in_poll),
        .limit   (tmo_limit),
        .expired (expired)
    );

    nor_toggle_eval #(.DW(DW)) u_eval (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_first   (state_q == ST_RD1),
        .cap_second  (state_q == ST_RD2),
        .rdata       (fl_rdata),
        .retry_armed (retry_q),
        .expired     (expired),
        .verdict     (verdict)
    );

    // Sequence the write, poll and recovery phases of one request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            erase_q <= 1'b0;
            retry_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            code_q  <= RES_OK;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    erase_q <= req_erase;
                    addr_q  <= req_addr;
                    data_q  <= req_data;
                    step_q  <= '0;
                    retry_q <= 1'b0;
                    state_q <= ST_WLO;
                end
                ST_WLO: state_q <= ST_WHI;
                ST_WHI: begin
                    if (rom_last) begin
                        state_q <= ST_RD1;
                    end else begin
                        step_q  <= step_q + 1'b1;
                        state_q <= ST_WLO;
                    end
                end
                ST_RD1: state_q <= ST_RD2;
                ST_RD2: state_q <= ST_CHK;
                ST_CHK: begin
                    case (verdict)
                        VERD_OK:    begin code_q <= RES_OK;     state_q <= ST_DONE; end
                        VERD_ERR:   begin code_q <= RES_DEVERR; state_q <= ST_RLO;  end
                        VERD_TMO:   begin code_q <= RES_TMO;    state_q <= ST_RLO;  end
                        VERD_RETRY: begin retry_q <= 1'b1;      state_q <= ST_RD1;  end
                        default:    state_q <= ST_RD1;
                    endcase
                end
                ST_RLO:  state_q <= ST_RHI;
                ST_RHI:  state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the flash bus from the current phase.
    always_comb begin
        word_addr = in_write ? rom_addr : addr_q;
        fl_addr   = BAW'(word_addr) << SH;
        if (in_write)
            fl_wdata = rom_data;
        else if (state_q == ST_RLO || state_q == ST_RHI)
            fl_wdata = DW'(CMD_RESET);
        else
            fl_wdata = '0;
    end

    assign fl_we_n   = !((state_q == ST_WLO) || (state_q == ST_RLO));
    assign fl_oe_n   = !((state_q == ST_RD1) || (state_q == ST_RD2));
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign done_code = code_q;

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    assert_write_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> fl_we_n);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_code != 2'd3));
    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_accept_starts_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && !fl_we_n));
endmodule

// File: tb/nor_unlock_seq_bench.sv
`timescale 1ns/1ps
module nor_unlock_seq_bench;
    localparam int AW  = 20;
    localparam int DW  = 16;
    localparam int TW  = 16;
    localparam int PWB = DW / 8;
    localparam int BAW = AW + 1;

    typedef struct packed {
        logic          erase;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [7:0]    tog;
        logic          e5;
        logic [TW-1:0] lim;
        logic [1:0]    code;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 20'h01234, 16'hBEEF, 8'd0,   1'b0, 16'd100,  2'd0},
        '{1'b0, 20'h00010, 16'h1357, 8'd6,   1'b0, 16'd100,  2'd0},
        '{1'b1, 20'h40000, 16'h0000, 8'd4,   1'b0, 16'd100,  2'd0},
        '{1'b0, 20'h00FFF, 16'hA5A5, 8'd255, 1'b0, 16'd20,   2'd1},
        '{1'b1, 20'h20000, 16'h0000, 8'd255, 1'b1, 16'd1000, 2'd2},
        '{1'b0, 20'h00003, 16'h0F0F, 8'd2,   1'b1, 16'd1000, 2'd0},
        '{1'b1, 20'h7FFFF, 16'h0000, 8'd255, 1'b0, 16'd0,    2'd1},
        '{1'b0, 20'h00100, 16'h7777, 8'd4,   1'b1, 16'd1000, 2'd2}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_erase = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_data = '0;
    logic [TW-1:0]  tmo_limit = '0;
    logic           busy, done;
    logic [1:0]     done_code;
    logic [BAW-1:0] fl_addr;
    logic [DW-1:0]  fl_wdata;
    logic [DW-1:0]  fl_rdata = '0;
    logic           fl_we_n, fl_oe_n;

    nor_unlock_seq #(.AW(AW), .DW(DW), .TW(TW)) u_nor_unlock_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_data(req_data), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .done_code(done_code), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    // Flash model and bus monitor state.
    int             m_tog = 0;
    logic           m_e5 = 1'b0;
    int             rd_idx = 0;
    int             nw = 0;
    int             ndone = 0;
    logic [1:0]     last_code = '0;
    logic [BAW-1:0] wa [16];
    logic [DW-1:0]  wd [16];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // Answer reads from the script and log writes and done pulses.
    always @(negedge clk) begin
        if (!fl_oe_n) begin
            if (rd_idx < m_tog)
                fl_rdata <= {9'h0, rd_idx[0], m_e5, 5'h0};
            else
                fl_rdata <= 16'h0080;
            rd_idx <= rd_idx + 1;
        end
        if (!fl_we_n) begin
            if (nw < 16) begin
                wa[nw] <= fl_addr;
                wd[nw] <= fl_wdata;
            end
            nw <= nw + 1;
        end
        if (done) begin
            ndone <= ndone + 1;
            last_code <= done_code;
        end
    end

    // Round-by-round prediction of the number of reads (R6, R7, R8).
    function automatic int exp_reads(input int tog, input bit e5, input int lim);
        bit armed = 1'b0;
        for (int n = 1; n <= 200; n++) begin
            int k = 2 * (n - 1);
            bit toggled = (k < tog);
            bit fault = e5 && (k + 1 < tog);
            if (!toggled || armed || (3 * n - 1 >= lim)) return 2 * n;
            if (fault) armed = 1'b1;
        end
        return -1;
    endfunction

    task automatic clear_log();
        @(negedge clk);
        nw = 0; rd_idx = 0; ndone = 0;
    endtask

    task automatic issue(input logic er, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_erase = er; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (ndone == 0 && g < 5000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [BAW-1:0] ea [8];
        logic [DW-1:0]  ed [8];
        int ne;
        int er;
        m_tog = int'(v.tog); m_e5 = v.e5; tmo_limit = v.lim;
        clear_log();
        issue(v.erase, v.addr, v.data);
        wait_done();
        if (!v.erase) begin
            ea[0] = BAW'(12'h555 * PWB); ed[0] = 16'hAA;
            ea[1] = BAW'(12'h2AA * PWB); ed[1] = 16'h55;
            ea[2] = BAW'(12'h555 * PWB); ed[2] = 16'hA0;
            ea[3] = BAW'(v.addr) * PWB;  ed[3] = v.data;
            ne = 4;
        end else begin
            ea[0] = BAW'(12'h555 * PWB); ed[0] = 16'hAA;
            ea[1] = BAW'(12'h2AA * PWB); ed[1] = 16'h55;
            ea[2] = BAW'(12'h555 * PWB); ed[2] = 16'h80;
            ea[3] = BAW'(12'h555 * PWB); ed[3] = 16'hAA;
            ea[4] = BAW'(12'h2AA * PWB); ed[4] = 16'h55;
            ea[5] = BAW'(v.addr) * PWB;  ed[5] = 16'h30;
            ne = 6;
        end
        if (v.code != 2'd0) begin
            ea[ne] = BAW'(v.addr) * PWB; ed[ne] = 16'hF0;
            ne++;
        end
        check(ndone == 1, $sformatf("R9 vec%0d done pulses", idx), ndone, 1);
        check(last_code == v.code,
              $sformatf("R6/R7/R8 vec%0d result code", idx), int'(last_code), int'(v.code));
        check(nw == ne, $sformatf("R2/R3 vec%0d write count", idx), nw, ne);
        for (int i = 0; i < ne && i < nw; i++) begin
            check(wa[i] == ea[i], $sformatf("R4 vec%0d write%0d address", idx, i),
                  int'(wa[i]), int'(ea[i]));
            check(wd[i] == ed[i], $sformatf("R2/R3 vec%0d write%0d data", idx, i),
                  int'(wd[i]), int'(ed[i]));
        end
        er = exp_reads(int'(v.tog), v.e5, int'(v.lim));
        check(rd_idx == er, $sformatf("R6/R8 vec%0d read count", idx), rd_idx, er);
        check(!busy, $sformatf("R9 vec%0d busy after done", idx), int'(busy), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(fl_we_n && fl_oe_n && !busy && !done, "R1 outputs during reset",
              {fl_we_n, fl_oe_n, busy, done}, 4'b1100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(fl_we_n && fl_oe_n && !busy && !done, "R1 idle after reset",
              {fl_we_n, fl_oe_n, busy, done}, 4'b1100);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10: request during busy is ignored
        m_tog = 6; m_e5 = 1'b0; tmo_limit = 16'd100;
        clear_log();
        issue(1'b0, 20'h00055, 16'h1111);
        repeat (3) @(negedge clk);
        issue(1'b1, 20'h60000, 16'h2222);
        wait_done();
        repeat (20) @(negedge clk);
        check(nw == 4, "R10 writes with overlapping request", nw, 4);
        check(ndone == 1, "R10 done pulses with overlapping request", ndone, 1);
        check(wd[3] == 16'h1111, "R10 programmed data kept", int'(wd[3]), 16'h1111);

        // R1: reset in the middle of polling returns to idle
        m_tog = 255; m_e5 = 1'b0; tmo_limit = 16'd5000;
        clear_log();
        issue(1'b0, 20'h00077, 16'h3333);
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(fl_we_n && fl_oe_n && !busy && !done, "R1 idle after mid-poll reset",
              {fl_we_n, fl_oe_n, busy, done}, 4'b1100);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(!busy && ndone == 0, "R1 no done after aborted run", ndone, 0);

        finish_run();
    end
endmodule